// File: doc/BRIEF.md
# Translation Cache with Rights Check

This block keeps recently used page translations for a paged memory management unit. Each lookup presents a logical page number, a task alias and an access type (read or write, user or supervisor). A fully associative tag array compares the lookup against every stored entry. The tag is the page number and the alias together, so translations from several tasks can sit side by side. On a match, a separate physical-page store supplies the frame number, and the stored rights decide whether the access is allowed. If no entry matches, the miss output tells the surrounding logic to start a page-table search.

No strobe is needed to start a lookup: the key is sampled on every clock and the result appears one cycle later. When the page-table search returns, the searcher writes the new descriptor in through the fill port. An entry that already holds the same page and alias is refreshed in place. Otherwise the lowest-numbered empty slot is used. Once the cache is full, a binary pseudo-LRU tree names the entry to replace. Software can empty the whole cache, or only the entries that belong to one alias.

Top module: `xlc_cache`

## Requirements
- R1: After reset every entry is invalid and the outputs read o_miss=1, o_hit=0, o_fault=0, o_ppn=0. Every lookup misses until a fill has been made.
- R2: The outputs registered at a clock edge describe the key (i_lpn, i_alias, i_wr, i_sup) that was sampled at that same edge. Exactly one of o_hit, o_miss, o_fault is 1 in every cycle.
- R3: An entry matches only if it is valid and both its page number and its alias equal the lookup key. An entry stored under a different alias, or with a different page number, gives o_miss.
- R4: On an allowed match, o_hit=1 and o_ppn holds the frame number stored with that entry. While o_hit=0, o_ppn reads 0.
- R5: A match is denied when i_wr=1 and the entry is write-protected, or when i_sup=0 and the entry is supervisor-only. A denied match gives o_fault=1, o_hit=0 and o_ppn=0.
- R6: i_flush_all invalidates every entry. i_flush_alias_en invalidates only the entries whose alias equals i_flush_alias. A fill presented in the same cycle as either flush is dropped.
- R7: A fill is written to the entry that already holds the same page and alias, if there is one. Otherwise it goes to the lowest-numbered invalid entry. Otherwise it replaces the entry chosen by the tree.
- R8: The tree has N_ENT-1 bits, and all of them are 0 after reset. A touch of entry k sets each node on k's path to point at the half that does not hold k. The victim is found by following the node bits down from the root. A fill touches its entry. An allowed hit from a new lookup also touches its entry.
- R9: A lookup is new when its key differs from the key sampled in the previous cycle, or when it is the first cycle after reset. A repeated key, a miss and a fault leave the tree unchanged.
- R10: A lookup made in the same cycle as a fill or a flush sees the contents as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_lpn | input | LPN_W | Lookup logical page number |
| i_alias | input | ALIAS_W | Lookup task alias |
| i_wr | input | 1 | Lookup is a write |
| i_sup | input | 1 | Lookup is made in supervisor mode |
| i_fill | input | 1 | Load a descriptor this cycle |
| i_fill_lpn | input | LPN_W | Page number of the loaded descriptor |
| i_fill_alias | input | ALIAS_W | Alias of the loaded descriptor |
| i_fill_ppn | input | PPN_W | Frame number of the loaded descriptor |
| i_fill_wp | input | 1 | Loaded page is write-protected |
| i_fill_sup | input | 1 | Loaded page is supervisor-only |
| i_flush_all | input | 1 | Invalidate every entry |
| i_flush_alias_en | input | 1 | Invalidate the entries of one alias |
| i_flush_alias | input | ALIAS_W | Alias to invalidate |
| o_hit | output | 1 | Allowed translation found |
| o_miss | output | 1 | No entry matches; a table search is needed |
| o_fault | output | 1 | Entry matches but the rights deny the access |
| o_ppn | output | PPN_W | Translated frame number, 0 unless o_hit |

## Verification
The bench targets the following corner cases:
- **Lookup in the same cycle as a fill.** A design that let the new entry be seen in that cycle would report a hit one cycle early.
- **Refilling a page that is already cached.** A design that skipped the duplicate search would leave two matching tags, which would OR their frame numbers together.
- **Flushing one alias.** A design that ignored the alias would wipe entries that belong to other tasks.
- **Holding a key across a fill, then filling again.** A design that touched the tree on every cycle of a held hit, or on a fault, would evict a different entry than the arithmetic tree model predicts.

The bench also sweeps every key of a small configuration and runs a long pseudo-random mix of fills and flushes. Any slip in the rights decode or in the replacement walk therefore shows up as a wrong output on some cycle.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  typedef struct packed {
    logic wr_prot;
    logic sup_only;
  } xlc_rights_t;

  localparam int RIGHTS_W = $bits(xlc_rights_t);

  function automatic logic rights_deny(input xlc_rights_t r, input logic wr, input logic sup);
    return (wr & r.wr_prot) | (~sup & r.sup_only);
  endfunction

endpackage

// File: rtl/xlc_tag_cam.sv
module xlc_tag_cam
  import xlc_pkg::*;
#(
  parameter int N_ENT   = 64,
  parameter int LPN_W   = 20,
  parameter int ALIAS_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LPN_W-1:0]           i_look_lpn,
  input  logic [ALIAS_W-1:0]         i_look_alias,
  input  logic [LPN_W-1:0]           i_fill_lpn,
  input  logic [ALIAS_W-1:0]         i_fill_alias,
  input  logic                       i_we,
  input  logic [$clog2(N_ENT)-1:0]   i_widx,
  input  xlc_rights_t                i_wrights,
  input  logic                       i_flush_all,
  input  logic                       i_flush_alias_en,
  input  logic [ALIAS_W-1:0]         i_flush_alias,
  output logic [N_ENT-1:0]           o_look_match,
  output logic [N_ENT-1:0]           o_fill_match,
  output logic [N_ENT-1:0]           o_valid,
  output xlc_rights_t                o_look_rights
);

  logic [N_ENT-1:0]   vld_q;
  logic [LPN_W-1:0]   lpn_q [N_ENT];
  logic [ALIAS_W-1:0] al_q  [N_ENT];
  xlc_rights_t        rt_q  [N_ENT];
  logic [RIGHTS_W-1:0] rights_or;

  // valid bits: flushes take priority over a write
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (i_flush_all) begin
      vld_q <= '0;
    end else if (i_flush_alias_en) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (al_q[i] == i_flush_alias) vld_q[i] <= 1'b0;
      end
    end else if (i_we) begin
      vld_q[i_widx] <= 1'b1;
    end
  end

  // tag payload, no reset
  always_ff @(posedge clk) begin
    if (i_we) begin
      lpn_q[i_widx] <= i_fill_lpn;
      al_q[i_widx]  <= i_fill_alias;
      rt_q[i_widx]  <= i_wrights;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign o_look_match[g] = vld_q[g] && (lpn_q[g] == i_look_lpn) && (al_q[g] == i_look_alias);
    assign o_fill_match[g] = vld_q[g] && (lpn_q[g] == i_fill_lpn) && (al_q[g] == i_fill_alias);
  end

  always_comb begin
    rights_or = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (o_look_match[i]) rights_or = rights_or | rt_q[i];
    end
    o_look_rights = xlc_rights_t'(rights_or);
  end

  assign o_valid = vld_q;

  // R7: the refill-in-place rule keeps every tag unique
  p_unique_tag_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(o_look_match) && $onehot0(o_fill_match));

  // R6: a full flush leaves nothing valid
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (rst)
    i_flush_all |=> (vld_q == '0));

  // R7: a write without flush makes its slot valid
  p_write_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (i_we && !i_flush_all && !i_flush_alias_en) |=> vld_q[$past(i_widx)]);

endmodule

// File: rtl/xlc_plru.sv
module xlc_plru #(
  parameter int N_ENT = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     i_ta_en,
  input  logic [$clog2(N_ENT)-1:0] i_ta_idx,
  input  logic                     i_tb_en,
  input  logic [$clog2(N_ENT)-1:0] i_tb_idx,
  output logic [$clog2(N_ENT)-1:0] o_victim
);

  localparam int LVL = $clog2(N_ENT);

  logic [N_ENT-2:0] tree_q, tree_d;

  // node n has children 2n+1 (lower half) and 2n+2 (upper half);
  // a node bit names the half the victim lies in
  function automatic logic [N_ENT-2:0] touch(input logic [N_ENT-2:0] t, input logic [LVL-1:0] idx);
    int   node;
    logic b;
    node = 0;
    for (int l = 0; l < LVL; l++) begin
      b       = idx[LVL-1-l];
      t[node] = ~b;
      node    = 2 * node + 1 + int'(b);
    end
    return t;
  endfunction

  always_comb begin
    tree_d = tree_q;
    if (i_ta_en) tree_d = touch(tree_d, i_ta_idx);
    if (i_tb_en) tree_d = touch(tree_d, i_tb_idx);
  end

  always_comb begin
    int   node;
    logic b;
    node     = 0;
    o_victim = '0;
    for (int l = 0; l < LVL; l++) begin
      b                  = tree_q[node];
      o_victim[LVL-1-l]  = b;
      node               = 2 * node + 1 + int'(b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tree_q <= '0;
    else     tree_q <= tree_d;
  end

  // R8: the entry just touched is never the next victim
  p_fresh_not_victim_r8: assert property (@(posedge clk) disable iff (rst)
    (i_ta_en && !i_tb_en) |=> (o_victim != $past(i_ta_idx)));

  p_fill_not_victim_r8: assert property (@(posedge clk) disable iff (rst)
    i_tb_en |=> (o_victim != $past(i_tb_idx)));

endmodule

// File: rtl/xlc_phys_store.sv
module xlc_phys_store #(
  parameter int N_ENT = 64,
  parameter int PPN_W = 20
) (
  input  logic                     clk,
  input  logic                     i_we,
  input  logic [$clog2(N_ENT)-1:0] i_widx,
  input  logic [PPN_W-1:0]         i_wdata,
  input  logic [$clog2(N_ENT)-1:0] i_ridx,
  output logic [PPN_W-1:0]         o_rdata
);

  logic [PPN_W-1:0] mem [N_ENT];

  // simple dual port, read-before-write
  always_ff @(posedge clk) begin
    if (i_we) mem[i_widx] <= i_wdata;
    o_rdata <= mem[i_ridx];
  end

endmodule

// File: rtl/xlc_cache.sv
module xlc_cache
  import xlc_pkg::*;
#(
  parameter int N_ENT   = 64,
  parameter int LPN_W   = 20,
  parameter int ALIAS_W = 3,
  parameter int PPN_W   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LPN_W-1:0]   i_lpn,
  input  logic [ALIAS_W-1:0] i_alias,
  input  logic               i_wr,
  input  logic               i_sup,
  input  logic               i_fill,
  input  logic [LPN_W-1:0]   i_fill_lpn,
  input  logic [ALIAS_W-1:0] i_fill_alias,
  input  logic [PPN_W-1:0]   i_fill_ppn,
  input  logic               i_fill_wp,
  input  logic               i_fill_sup,
  input  logic               i_flush_all,
  input  logic               i_flush_alias_en,
  input  logic [ALIAS_W-1:0] i_flush_alias,
  output logic               o_hit,
  output logic               o_miss,
  output logic               o_fault,
  output logic [PPN_W-1:0]   o_ppn
);

  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] look_match, fill_match, vld;
  xlc_rights_t      hit_rights, fill_rights;
  logic [IDX_W-1:0] hit_idx, dup_idx, inv_idx, victim, fill_idx;
  logic             hit_any, deny, inv_any, fill_ok, new_look, touch_hit;
  logic [PPN_W-1:0] rd_ppn;

  // previous key, for change detection
  logic [LPN_W-1:0]   pk_lpn_q;
  logic [ALIAS_W-1:0] pk_al_q;
  logic               pk_wr_q, pk_sup_q, seen_q;

  assign fill_rights = '{wr_prot: i_fill_wp, sup_only: i_fill_sup};
  assign fill_ok     = i_fill & ~i_flush_all & ~i_flush_alias_en;

  xlc_tag_cam #(.N_ENT(N_ENT), .LPN_W(LPN_W), .ALIAS_W(ALIAS_W)) u_cam (
    .clk              (clk),
    .rst              (rst),
    .i_look_lpn       (i_lpn),
    .i_look_alias     (i_alias),
    .i_fill_lpn       (i_fill_lpn),
    .i_fill_alias     (i_fill_alias),
    .i_we             (fill_ok),
    .i_widx           (fill_idx),
    .i_wrights        (fill_rights),
    .i_flush_all      (i_flush_all),
    .i_flush_alias_en (i_flush_alias_en),
    .i_flush_alias    (i_flush_alias),
    .o_look_match     (look_match),
    .o_fill_match     (fill_match),
    .o_valid          (vld),
    .o_look_rights    (hit_rights)
  );

  // one-hot to index, lowest invalid slot
  always_comb begin
    hit_idx = '0;
    dup_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (look_match[i]) hit_idx = hit_idx | IDX_W'(i);
      if (fill_match[i]) dup_idx = dup_idx | IDX_W'(i);
    end
  end

  always_comb begin
    inv_idx = '0;
    inv_any = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        inv_idx = IDX_W'(i);
        inv_any = 1'b1;
      end
    end
  end

  assign hit_any   = |look_match;
  assign deny      = hit_any & rights_deny(hit_rights, i_wr, i_sup);
  assign new_look  = ~seen_q | (i_lpn != pk_lpn_q) | (i_alias != pk_al_q) |
                     (i_wr != pk_wr_q) | (i_sup != pk_sup_q);
  assign touch_hit = new_look & hit_any & ~deny;
  assign fill_idx  = (|fill_match) ? dup_idx : (inv_any ? inv_idx : victim);

  xlc_plru #(.N_ENT(N_ENT)) u_plru (
    .clk      (clk),
    .rst      (rst),
    .i_ta_en  (touch_hit),
    .i_ta_idx (hit_idx),
    .i_tb_en  (fill_ok),
    .i_tb_idx (fill_idx),
    .o_victim (victim)
  );

  xlc_phys_store #(.N_ENT(N_ENT), .PPN_W(PPN_W)) u_store (
    .clk     (clk),
    .i_we    (fill_ok),
    .i_widx  (fill_idx),
    .i_wdata (i_fill_ppn),
    .i_ridx  (hit_idx),
    .o_rdata (rd_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      pk_lpn_q <= '0;
      pk_al_q  <= '0;
      pk_wr_q  <= 1'b0;
      pk_sup_q <= 1'b0;
      o_hit    <= 1'b0;
      o_miss   <= 1'b1;
      o_fault  <= 1'b0;
    end else begin
      seen_q   <= 1'b1;
      pk_lpn_q <= i_lpn;
      pk_al_q  <= i_alias;
      pk_wr_q  <= i_wr;
      pk_sup_q <= i_sup;
      o_hit    <= hit_any & ~deny;
      o_miss   <= ~hit_any;
      o_fault  <= deny;
    end
  end

  assign o_ppn = o_hit ? rd_ppn : '0;

  // R2: one outcome per cycle
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({o_hit, o_miss, o_fault}) == 1);

  // R1: an empty cache can only miss
  p_empty_misses_r1: assert property (@(posedge clk) disable iff (rst)
    (vld == '0) |=> o_miss);

  // R10/R7: a filled key seen again on the next cycle no longer misses
  p_fill_then_found_r10: assert property (@(posedge clk) disable iff (rst)
    (fill_ok && i_fill_lpn == i_lpn && i_fill_alias == i_alias) ##1
    (!i_flush_all && !i_flush_alias_en && $stable(i_lpn) && $stable(i_alias))
    |=> !o_miss);

endmodule

// File: tb/xlc_cache_bench.sv
module xlc_cache_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int L   = 3;
  localparam int LW  = 6;
  localparam int AW  = 2;
  localparam int PW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] i_lpn = '0;
  logic [AW-1:0] i_alias = '0;
  logic          i_wr = 1'b0, i_sup = 1'b1;
  logic          i_fill = 1'b0;
  logic [LW-1:0] i_fill_lpn = '0;
  logic [AW-1:0] i_fill_alias = '0;
  logic [PW-1:0] i_fill_ppn = '0;
  logic          i_fill_wp = 1'b0, i_fill_sup = 1'b0;
  logic          i_flush_all = 1'b0, i_flush_alias_en = 1'b0;
  logic [AW-1:0] i_flush_alias = '0;
  logic          o_hit, o_miss, o_fault;
  logic [PW-1:0] o_ppn;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlc_cache #(.N_ENT(N), .LPN_W(LW), .ALIAS_W(AW), .PPN_W(PW)) u_xlc_cache (
    .clk(clk), .rst(rst), .i_lpn(i_lpn), .i_alias(i_alias), .i_wr(i_wr), .i_sup(i_sup),
    .i_fill(i_fill), .i_fill_lpn(i_fill_lpn), .i_fill_alias(i_fill_alias),
    .i_fill_ppn(i_fill_ppn), .i_fill_wp(i_fill_wp), .i_fill_sup(i_fill_sup),
    .i_flush_all(i_flush_all), .i_flush_alias_en(i_flush_alias_en),
    .i_flush_alias(i_flush_alias), .o_hit(o_hit), .o_miss(o_miss), .o_fault(o_fault),
    .o_ppn(o_ppn)
  );

  int total = 0;
  int bad   = 0;

  // reference model
  int m_vld [N];
  int m_lpn [N];
  int m_al  [N];
  int m_ppn [N];
  int m_wp  [N];
  int m_sp  [N];
  int m_tr  [N];   // heap nodes 1..N-1, children 2k and 2k+1
  int m_prev;
  int m_prev_ok;

  task automatic check1(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tr[i] = 0; end
    m_prev_ok = 0;
    m_prev = 0;
  endtask

  task automatic m_touch(input int idx);
    int k = 1;
    for (int l = L - 1; l >= 0; l--) begin
      int b = (idx >> l) & 1;
      m_tr[k] = (b == 0) ? 1 : 0;
      k = 2 * k + b;
    end
  endtask

  function automatic int m_victim();
    int k = 1;
    int v = 0;
    for (int l = 0; l < L; l++) begin
      int b = m_tr[k];
      v = v * 2 + b;
      k = 2 * k + b;
    end
    return v;
  endfunction

  function automatic int m_target(input int lp, input int al);
    for (int i = 0; i < N; i++)
      if (m_vld[i] != 0 && m_lpn[i] == lp && m_al[i] == al) return i;
    for (int i = 0; i < N; i++)
      if (m_vld[i] == 0) return i;
    return m_victim();
  endfunction

  // one clock: inputs already driven at a falling edge
  task automatic step(input string req);
    int mi = -1;
    int eh = 0, ef = 0, em = 0, ep = 0;
    int key, nl, fe, tgt;
    int lp = int'(i_lpn), al = int'(i_alias), wr = int'(i_wr), sp = int'(i_sup);
    int fl = int'(i_fill_lpn), fa = int'(i_fill_alias), fp = int'(i_fill_ppn);
    int fw = int'(i_fill_wp), fs = int'(i_fill_sup);
    int fla = int'(i_flush_all), fln = int'(i_flush_alias_en), flv = int'(i_flush_alias);
    string tag;
    for (int i = 0; i < N; i++)
      if (m_vld[i] != 0 && m_lpn[i] == lp && m_al[i] == al) mi = i;
    if (mi < 0) em = 1;
    else if ((wr != 0 && m_wp[mi] != 0) || (sp == 0 && m_sp[mi] != 0)) ef = 1;
    else begin eh = 1; ep = m_ppn[mi]; end
    key = (lp << 4) | (al << 2) | (wr << 1) | sp;
    nl  = (m_prev_ok == 0 || key != m_prev) ? 1 : 0;
    fe  = (i_fill && fla == 0 && fln == 0) ? 1 : 0;
    tgt = m_target(fl, fa);
    @(posedge clk);
    if (nl != 0 && eh != 0) m_touch(mi);
    if (fla != 0) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else if (fln != 0) begin
      for (int i = 0; i < N; i++) if (m_al[i] == flv) m_vld[i] = 0;
    end
    if (fe != 0) begin
      m_vld[tgt] = 1; m_lpn[tgt] = fl; m_al[tgt] = fa; m_ppn[tgt] = fp;
      m_wp[tgt] = fw; m_sp[tgt] = fs;
      m_touch(tgt);
    end
    m_prev = key;
    m_prev_ok = 1;
    @(negedge clk);
    tag = (req.len() != 0) ? req : (ef != 0 ? "R5" : (eh != 0 ? "R4" : "R3"));
    check1(tag, "hit", int'(o_hit), eh);
    check1(tag, "miss", int'(o_miss), em);
    check1(tag, "fault", int'(o_fault), ef);
    check1(tag, "ppn", int'(o_ppn), ep);
    i_fill = 1'b0;
    i_flush_all = 1'b0;
    i_flush_alias_en = 1'b0;
  endtask

  task automatic look(input int lp, input int al, input int wr, input int sp, input string req);
    i_lpn = LW'(lp); i_alias = AW'(al); i_wr = wr[0]; i_sup = sp[0];
    step(req);
  endtask

  task automatic fill_on(input int lp, input int al, input int pp, input int wp, input int sp);
    i_fill = 1'b1; i_fill_lpn = LW'(lp); i_fill_alias = AW'(al);
    i_fill_ppn = PW'(pp); i_fill_wp = wp[0]; i_fill_sup = sp[0];
  endtask

  task automatic sweep(input string req);
    for (int lp = 0; lp < 64; lp++)
      for (int al = 0; al < 4; al++)
        look(lp, al, lp & 1, (lp >> 1) & 1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check1("R1", "miss", int'(o_miss), 1);
    check1("R1", "hit", int'(o_hit), 0);
    check1("R1", "fault", int'(o_fault), 0);
    check1("R1", "ppn", int'(o_ppn), 0);
    for (int lp = 0; lp < 64; lp++) look(lp, lp % 4, 0, 1, "R1");

    // fill all slots with mixed rights (R7 lowest invalid first)
    for (int i = 0; i < N; i++) begin
      fill_on(i * 5 + 1, i % 4, 16 + i * 7, i & 1, (i >> 1) & 1);
      look(63, 3, 0, 1, "R7");
    end
    // R2..R5 exhaustive over keys and access types
    for (int lp = 0; lp < 64; lp++)
      for (int al = 0; al < 4; al++)
        for (int ac = 0; ac < 4; ac++)
          look(lp, al, ac & 1, ac >> 1, "");

    // R8: ninth fill evicts the tree victim
    fill_on(50, 2, 200, 0, 0);
    look(1, 0, 0, 1, "R8");
    sweep("R8");

    // R10: lookup in the fill cycle sees the old contents
    fill_on(40, 1, 77, 0, 0);
    look(40, 1, 0, 1, "R10");
    look(40, 1, 0, 1, "R10");

    // R7: refill of a cached key updates in place
    fill_on(40, 1, 99, 1, 0);
    look(40, 1, 0, 1, "R7");
    look(40, 1, 0, 1, "R7");
    sweep("R7");

    // R9: a held hit across fills must not re-touch the tree
    look(40, 1, 0, 1, "R9");
    fill_on(60, 0, 61, 0, 0);
    look(40, 1, 0, 1, "R9");
    look(40, 1, 0, 1, "R9");
    fill_on(61, 0, 62, 0, 0);
    look(40, 1, 0, 1, "R9");
    fill_on(62, 0, 63, 0, 0);
    look(40, 1, 0, 1, "R9");
    sweep("R9");

    // R6: alias flush, dropped fill, full flush
    i_flush_alias_en = 1'b1; i_flush_alias = 2'd1;
    look(0, 0, 0, 1, "R6");
    sweep("R6");
    i_flush_all = 1'b1;
    fill_on(33, 3, 5, 0, 0);
    look(33, 3, 0, 1, "R6");
    look(33, 3, 0, 1, "R6");
    sweep("R6");

    // mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      int op;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = int'(lf[3:0]);
      if (op == 14) begin
        i_flush_alias_en = 1'b1; i_flush_alias = lf[6:5];
      end else if (op == 15 && lf[8:7] == 2'b00) begin
        i_flush_all = 1'b1;
      end else if (op >= 11) begin
        fill_on(int'(lf[11:8]) % 12, int'(lf[13:12]), int'(lf[15:8]), int'(lf[4]), int'(lf[5]));
      end
      if (op < 8) look(int'(lf[11:8]) % 12, int'(lf[13:12]), int'(lf[4]), int'(lf[14]), "R8");
      else step("R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule